// File: doc/BRIEF.md
# CAN Fault-Confinement Error Counters

This block keeps the transmit and receive error counts of a CAN node and derives its fault-confinement state from them. The protocol engine sends it one-cycle event strobes: a receive error, a dominant bit right after an error flag, a transmitted error flag, and a bit error while the node drives an active error or overload flag. It also sends the qualifiers that exempt a transmitted error flag from counting, and strobes for a successful transmission or reception. All rules that fire in one cycle are summed into a single update of each counter.

The CPU can load the counters through a write port. One write sets both counts to the same value. A synchronous controller-reset input and the system reset both clear the counts. In bus-off the counts are frozen until the recovery condition is met. That condition needs the controller enabled and 128 reports of eleven consecutive recessive bits. Nothing else touches the counts, so a low-power entry or exit leaves them as they were.

The controller has three states. ST_ACTIVE is error-active. ST_PASSIVE is error-passive. ST_BUSOFF is bus-off. The transitions are:
- ACTIVE to PASSIVE when an update leaves either count at 128 or more.
- PASSIVE to ACTIVE when an update leaves both counts below 128.
- ACTIVE or PASSIVE to BUSOFF when the transmit count would pass 255.
- BUSOFF to ACTIVE when recovery completes.
- Any state to ACTIVE on controller reset.

Top module: `can_fault_counters`

## Requirements
- R1: While rst_n is low, and on the clock edge after a cycle with ctl_reset high, both counts become 0 and only err_active is high. ctl_reset takes priority over every other input.
- R2: Outside bus-off, a cycle with cpu_wr high loads cpu_wdata into both tec and rec at the next edge, instead of any event update in that cycle.
- R3: rx_err adds 1 to rec. It adds nothing when rx_flag_bit_err is also high in the same cycle.
- R4: rx_dom_after_flag adds 8 to rec. rx_flag_bit_err also adds 8 to rec.
- R5: tx_err_flag adds 8 to tec, with two exceptions. It adds nothing when tx_arb_stuff is high. It also adds nothing when tx_ack_quiet is high and the node is currently error-passive. When the node is error-active, tx_ack_quiet has no effect.
- R6: tx_flag_bit_err adds 8 to tec.
- R7: All strobes in one cycle act together in a single update. rec saturates at 255.
- R8: tx_ok subtracts 1 from tec and rx_ok subtracts 1 from rec. No subtraction happens when the count was 0 before the update, and any increments in the same cycle still apply.
- R9: err_passive is high when either count is 128 or more. Otherwise err_active is high. Exactly one of err_active, err_passive and bus_off is high at any time.
- R10: When an update would take tec above 255, the node enters bus-off: bus_off goes high and both counts keep their values from before that update. In bus-off, event strobes and CPU writes change nothing.
- R11: In bus-off, each cycle with bus_enable and recessive11 both high counts one recovery step. A cycle with bus_enable low restarts the count. On the edge that completes the 128th step, both counts become 0 and err_active goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| ctl_reset | input | 1 | Synchronous controller reset |
| rx_err | input | 1 | Receiver detected an error |
| rx_flag_bit_err | input | 1 | Receiver saw a bit error while sending an active error or overload flag |
| rx_dom_after_flag | input | 1 | Receiver saw a dominant bit as the first bit after its error flag |
| tx_err_flag | input | 1 | Transmitter sent an error flag |
| tx_ack_quiet | input | 1 | Qualifier: acknowledge error and no dominant bit during the passive error flag |
| tx_arb_stuff | input | 1 | Qualifier: stuff error in arbitration on a recessive bit read back dominant |
| tx_flag_bit_err | input | 1 | Transmitter saw a bit error while sending an active error or overload flag |
| tx_ok | input | 1 | Successful transmission |
| rx_ok | input | 1 | Successful reception |
| cpu_wr | input | 1 | CPU write strobe for the counters |
| cpu_wdata | input | 8 | Value loaded into both counters |
| bus_enable | input | 1 | Controller enabled for bus-off recovery |
| recessive11 | input | 1 | Eleven consecutive recessive bits observed |
| tec | output | 8 | Transmit error count |
| rec | output | 8 | Receive error count |
| err_active | output | 1 | Node is error-active |
| err_passive | output | 1 | Node is error-passive |
| bus_off | output | 1 | Node is bus-off |

## Verification
The update is tried with each strobe alone and with the strobes that interact. The pairs show that the +1 receive rule is suppressed, that tx_ack_quiet counts only when the node is error-passive, and that a decrement is blocked by the old count of zero and not by the new one. Mixed cycles with several strobes separate one summed update from a last-writer-wins update, and a large starting value exposes rec saturation. Starting values around 127, 128 and 255 tell apart the threshold compares and the bus-off entry. Recovery runs are stopped at 127 steps and interrupted by bus_enable going low, which separates a correct count from off-by-one and non-restarting counters.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;

    typedef enum logic [1:0] {
        ST_ACTIVE  = 2'd0,
        ST_PASSIVE = 2'd1,
        ST_BUSOFF  = 2'd2
    } fc_state_e;

    typedef struct packed {
        logic rx_err;
        logic rx_flag_bit_err;
        logic rx_dom_after_flag;
        logic tx_err_flag;
        logic tx_ack_quiet;
        logic tx_arb_stuff;
        logic tx_flag_bit_err;
        logic tx_ok;
        logic rx_ok;
    } fc_events_t;

endpackage

// File: rtl/can_fc_delta.sv
module can_fc_delta
    import can_fc_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int STEP  = 8
) (
    input  logic [CNT_W-1:0] tec_i,
    input  logic [CNT_W-1:0] rec_i,
    input  fc_events_t       ev_i,
    input  logic             passive_i,
    output logic [CNT_W-1:0] tec_next_o,
    output logic             tec_ovf_o,
    output logic [CNT_W-1:0] rec_next_o
);
    localparam int SUM_W = CNT_W + 2;
    localparam logic [SUM_W-1:0] STEP_S = SUM_W'(STEP);
    localparam logic [SUM_W-1:0] MAX_S  = SUM_W'((1 << CNT_W) - 1);
    localparam logic [SUM_W-1:0] ONE_S  = SUM_W'(1);

    logic             flag_counts;
    logic [SUM_W-1:0] tec_acc;
    logic [SUM_W-1:0] rec_acc;

    always_comb begin
        // exemptions for a transmitted error flag
        flag_counts = ev_i.tx_err_flag && !ev_i.tx_arb_stuff
                      && !(passive_i && ev_i.tx_ack_quiet);

        tec_acc = SUM_W'(tec_i);
        if (flag_counts)             tec_acc = tec_acc + STEP_S;
        if (ev_i.tx_flag_bit_err)    tec_acc = tec_acc + STEP_S;
        if (ev_i.tx_ok && tec_i != '0) tec_acc = tec_acc - ONE_S;

        rec_acc = SUM_W'(rec_i);
        if (ev_i.rx_err && !ev_i.rx_flag_bit_err) rec_acc = rec_acc + ONE_S;
        if (ev_i.rx_dom_after_flag)  rec_acc = rec_acc + STEP_S;
        if (ev_i.rx_flag_bit_err)    rec_acc = rec_acc + STEP_S;
        if (ev_i.rx_ok && rec_i != '0) rec_acc = rec_acc - ONE_S;

        tec_ovf_o  = tec_acc > MAX_S;
        tec_next_o = tec_acc[CNT_W-1:0];
        rec_next_o = (rec_acc > MAX_S) ? MAX_S[CNT_W-1:0] : rec_acc[CNT_W-1:0];
    end

endmodule

// File: rtl/can_fc_recovery.sv
module can_fc_recovery #(
    parameter int COUNT = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic run_i,
    input  logic strobe_i,
    output logic done_o
);
    localparam int CW = $clog2(COUNT + 1);
    localparam logic [CW-1:0] LAST = CW'(COUNT - 1);

    logic [CW-1:0] cnt_q;

    assign done_o = run_i && strobe_i && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i || !run_i || done_o) begin
            cnt_q <= '0;
        end else if (strobe_i) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    // R11: step count never reaches the limit without completing
    assert_cnt_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(COUNT));

    // R11: a cycle with recovery not running leaves the count at zero
    assert_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> cnt_q == '0);

endmodule

// File: rtl/can_fault_counters.sv
module can_fault_counters
    import can_fc_pkg::*;
#(
    parameter int CNT_W          = 8,
    parameter int FLAG_STEP      = 8,
    parameter int PASSIVE_LIMIT  = 128,
    parameter int RECOVERY_COUNT = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_reset,
    input  logic             rx_err,
    input  logic             rx_flag_bit_err,
    input  logic             rx_dom_after_flag,
    input  logic             tx_err_flag,
    input  logic             tx_ack_quiet,
    input  logic             tx_arb_stuff,
    input  logic             tx_flag_bit_err,
    input  logic             tx_ok,
    input  logic             rx_ok,
    input  logic             cpu_wr,
    input  logic [CNT_W-1:0] cpu_wdata,
    input  logic             bus_enable,
    input  logic             recessive11,
    output logic [CNT_W-1:0] tec,
    output logic [CNT_W-1:0] rec,
    output logic             err_active,
    output logic             err_passive,
    output logic             bus_off
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(PASSIVE_LIMIT);

    fc_state_e        state_q, state_d;
    logic [CNT_W-1:0] tec_q, tec_d, rec_q, rec_d;
    logic [CNT_W-1:0] tec_upd, rec_upd;
    logic             tec_ovf, rec_done;
    fc_events_t       ev;

    assign ev = '{rx_err: rx_err, rx_flag_bit_err: rx_flag_bit_err,
                  rx_dom_after_flag: rx_dom_after_flag, tx_err_flag: tx_err_flag,
                  tx_ack_quiet: tx_ack_quiet, tx_arb_stuff: tx_arb_stuff,
                  tx_flag_bit_err: tx_flag_bit_err, tx_ok: tx_ok, rx_ok: rx_ok};

    can_fc_delta #(.CNT_W(CNT_W), .STEP(FLAG_STEP)) u_delta (
        .tec_i      (tec_q),
        .rec_i      (rec_q),
        .ev_i       (ev),
        .passive_i  (state_q == ST_PASSIVE),
        .tec_next_o (tec_upd),
        .tec_ovf_o  (tec_ovf),
        .rec_next_o (rec_upd)
    );

    can_fc_recovery #(.COUNT(RECOVERY_COUNT)) u_recovery (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (ctl_reset),
        .run_i    ((state_q == ST_BUSOFF) && bus_enable),
        .strobe_i (recessive11),
        .done_o   (rec_done)
    );

    // next-state and next-count logic
    always_comb begin
        state_d = state_q;
        tec_d   = tec_q;
        rec_d   = rec_q;
        if (ctl_reset) begin
            state_d = ST_ACTIVE;
            tec_d   = '0;
            rec_d   = '0;
        end else begin
            unique case (state_q)
                ST_ACTIVE, ST_PASSIVE: begin
                    if (cpu_wr) begin
                        tec_d = cpu_wdata;
                        rec_d = cpu_wdata;
                    end else if (!tec_ovf) begin
                        tec_d = tec_upd;
                        rec_d = rec_upd;
                    end
                    if (!cpu_wr && tec_ovf)
                        state_d = ST_BUSOFF;
                    else if (tec_d >= LIMIT || rec_d >= LIMIT)
                        state_d = ST_PASSIVE;
                    else
                        state_d = ST_ACTIVE;
                end
                ST_BUSOFF: begin
                    if (rec_done) begin
                        state_d = ST_ACTIVE;
                        tec_d   = '0;
                        rec_d   = '0;
                    end
                end
                default: state_d = ST_ACTIVE;
            endcase
        end
    end

    // state and counter registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ACTIVE;
            tec_q   <= '0;
            rec_q   <= '0;
        end else begin
            state_q <= state_d;
            tec_q   <= tec_d;
            rec_q   <= rec_d;
        end
    end

    // outputs
    always_comb begin
        tec         = tec_q;
        rec         = rec_q;
        err_active  = (state_q == ST_ACTIVE);
        err_passive = (state_q == ST_PASSIVE);
        bus_off     = (state_q == ST_BUSOFF);
    end

    // R1: controller reset clears both counts
    assert_ctl_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_reset |=> (tec_q == '0 && rec_q == '0 && err_active));

    // R2: a CPU write outside bus-off leaves both counts equal
    assert_cpu_both_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !ctl_reset && state_q != ST_BUSOFF) |=> tec_q == rec_q);

    // R9: exactly one state output at a time
    assert_one_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({err_active, err_passive, bus_off}) == 1);

    // R9: passive flag agrees with the counts
    assert_passive_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_off |-> (err_passive == (tec_q >= LIMIT || rec_q >= LIMIT)));

    // R10: counts frozen in bus-off until recovery or reset
    assert_busoff_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_off && !rec_done && !ctl_reset) |=> ($stable(tec_q) && $stable(rec_q) && bus_off));

    // R11: no exit from bus-off while the controller is disabled
    assert_no_exit_disabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_off && !bus_enable && !ctl_reset) |=> bus_off);

endmodule

// File: tb/can_fault_counters_test.sv
module can_fault_counters_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_reset = 1'b0;
    logic       rx_err = 1'b0, rx_flag_bit_err = 1'b0, rx_dom_after_flag = 1'b0;
    logic       tx_err_flag = 1'b0, tx_ack_quiet = 1'b0, tx_arb_stuff = 1'b0;
    logic       tx_flag_bit_err = 1'b0, tx_ok = 1'b0, rx_ok = 1'b0;
    logic       cpu_wr = 1'b0;
    logic [7:0] cpu_wdata = 8'd0;
    logic       bus_enable = 1'b0, recessive11 = 1'b0;
    logic [7:0] tec, rec;
    logic       err_active, err_passive, bus_off;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    can_fault_counters uut (
        .clk(clk), .rst_n(rst_n), .ctl_reset(ctl_reset),
        .rx_err(rx_err), .rx_flag_bit_err(rx_flag_bit_err),
        .rx_dom_after_flag(rx_dom_after_flag), .tx_err_flag(tx_err_flag),
        .tx_ack_quiet(tx_ack_quiet), .tx_arb_stuff(tx_arb_stuff),
        .tx_flag_bit_err(tx_flag_bit_err), .tx_ok(tx_ok), .rx_ok(rx_ok),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .bus_enable(bus_enable),
        .recessive11(recessive11), .tec(tec), .rec(rec),
        .err_active(err_active), .err_passive(err_passive), .bus_off(bus_off)
    );

    // vector: {req, preload, events, exp tec, exp rec, exp state}
    // events bits 8..0: rx_err, rx_flag_bit_err, rx_dom_after_flag, tx_err_flag,
    //                   tx_ack_quiet, tx_arb_stuff, tx_flag_bit_err, tx_ok, rx_ok
    // state: 0 active, 1 passive, 2 bus-off
    localparam int NV = 19;
    localparam logic [38:0] VECS [NV] = '{
        {4'd3, 8'd10,  9'b100000000, 8'd10,  8'd11,  2'd0}, // R3 plain +1
        {4'd3, 8'd10,  9'b110000000, 8'd10,  8'd18,  2'd0}, // R3 +1 suppressed
        {4'd4, 8'd10,  9'b001000000, 8'd10,  8'd18,  2'd0}, // R4 dominant after flag
        {4'd4, 8'd10,  9'b010000000, 8'd10,  8'd18,  2'd0}, // R4 flag bit error rx
        {4'd5, 8'd10,  9'b000100000, 8'd18,  8'd10,  2'd0}, // R5 error flag
        {4'd5, 8'd10,  9'b000110000, 8'd18,  8'd10,  2'd0}, // R5 ack quiet while active
        {4'd5, 8'd130, 9'b000110000, 8'd130, 8'd130, 2'd1}, // R5 ack quiet while passive
        {4'd5, 8'd10,  9'b000101000, 8'd10,  8'd10,  2'd0}, // R5 arbitration stuff
        {4'd6, 8'd10,  9'b000000100, 8'd18,  8'd10,  2'd0}, // R6 flag bit error tx
        {4'd7, 8'd10,  9'b000100110, 8'd25,  8'd10,  2'd0}, // R7 combined tx
        {4'd7, 8'd250, 9'b111000000, 8'd250, 8'd255, 2'd1}, // R7 rec saturation
        {4'd8, 8'd0,   9'b000000011, 8'd0,   8'd0,   2'd0}, // R8 floor at zero
        {4'd8, 8'd5,   9'b000000011, 8'd4,   8'd4,   2'd0}, // R8 decrement
        {4'd8, 8'd0,   9'b000100010, 8'd8,   8'd0,   2'd0}, // R8 old value zero
        {4'd9, 8'd120, 9'b000100000, 8'd128, 8'd120, 2'd1}, // R9 enter passive
        {4'd9, 8'd128, 9'b000000010, 8'd127, 8'd128, 2'd1}, // R9 rec keeps passive
        {4'd9, 8'd128, 9'b000000011, 8'd127, 8'd127, 2'd0}, // R9 back to active
        {4'd10, 8'd247, 9'b000100000, 8'd255, 8'd247, 2'd1}, // R10 edge below bus-off
        {4'd2, 8'd77,  9'b000000000, 8'd77,  8'd77,  2'd0}  // R2 write loads both
    };

    function automatic logic [1:0] st_code();
        if (bus_off && !err_active && !err_passive) return 2'd2;
        if (err_passive && !err_active && !bus_off) return 2'd1;
        if (err_active && !err_passive && !bus_off) return 2'd0;
        return 2'd3;
    endfunction

    task automatic check(input string req, input logic [7:0] et, input logic [7:0] er,
                         input logic [1:0] es);
        checks++;
        if (tec !== et || rec !== er || st_code() !== es) begin
            failures++;
            $display("FAIL %s: tec=%0d rec=%0d st=%0d expected tec=%0d rec=%0d st=%0d",
                     req, tec, rec, st_code(), et, er, es);
        end
    endtask

    task automatic set_events(input logic [8:0] e);
        {rx_err, rx_flag_bit_err, rx_dom_after_flag, tx_err_flag, tx_ack_quiet,
         tx_arb_stuff, tx_flag_bit_err, tx_ok, rx_ok} = e;
    endtask

    task automatic cpu_write(input logic [7:0] v);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_wdata = v;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic pulse_events(input logic [8:0] e);
        set_events(e);
        @(negedge clk);
        set_events(9'd0);
    endtask

    task automatic strobes(input int n);
        recessive11 = 1'b1;
        repeat (n) @(negedge clk);
        recessive11 = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", 8'd0, 8'd0, 2'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", 8'd0, 8'd0, 2'd0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vector %0d", VECS[i][38:35], i);
            cpu_write(VECS[i][34:27]);
            pulse_events(VECS[i][26:18]);
            check(tag, VECS[i][17:10], VECS[i][9:2], VECS[i][1:0]);
        end

        // R1: controller reset clears nonzero counts
        cpu_write(8'd200);
        ctl_reset = 1'b1;
        @(negedge clk);
        ctl_reset = 1'b0;
        check("R1 ctl_reset", 8'd0, 8'd0, 2'd0);

        // R10: overflow enters bus-off and keeps the counts
        cpu_write(8'd250);
        pulse_events(9'b000100000);
        check("R10 enter bus-off", 8'd250, 8'd250, 2'd2);

        // R10: events and CPU writes ignored in bus-off
        pulse_events(9'b111111111);
        check("R10 events ignored", 8'd250, 8'd250, 2'd2);
        cpu_write(8'd3);
        check("R10 write ignored", 8'd250, 8'd250, 2'd2);

        // R11: strobes with controller disabled do not count
        bus_enable = 1'b0;
        strobes(200);
        check("R11 disabled", 8'd250, 8'd250, 2'd2);

        // R11: partial run, then disable restarts the count
        bus_enable = 1'b1;
        strobes(100);
        bus_enable = 1'b0;
        @(negedge clk);
        bus_enable = 1'b1;
        strobes(127);
        check("R11 127 steps", 8'd250, 8'd250, 2'd2);
        strobes(1);
        check("R11 recovered", 8'd0, 8'd0, 2'd0);
        bus_enable = 1'b0;

        // R1: controller reset also leaves bus-off
        cpu_write(8'd255);
        pulse_events(9'b000000100);
        check("R10 enter bus-off again", 8'd255, 8'd255, 2'd2);
        ctl_reset = 1'b1;
        @(negedge clk);
        ctl_reset = 1'b0;
        check("R1 ctl_reset from bus-off", 8'd0, 8'd0, 2'd0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run incomplete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule